// File: doc/BRIEF.md
# Branch Target Buffer with Saturating Counters

This block predicts the next fetch address for a pipelined processor that uses word addressing. It is a small direct-mapped table indexed by the low bits of the fetch PC. Each entry holds a valid flag, the remaining upper PC bits as a tag, the address a branch went to when it was taken, and a 2-bit saturating confidence counter. The fall-through address is never stored. It is always formed as PC+1.

The lookup side is purely combinational. The fetch stage presents its PC and gets back a hit flag, a predict-taken flag and the next PC to fetch in the same cycle. When a branch resolves further down the pipeline, the resolve port reports its PC, its outcome and its taken target. A branch that already has an entry trains that entry's counter. A branch with no entry, or with an entry now held by another branch on the same index, gets a fresh entry.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: On a lookup miss, `lk_hit` and `lk_taken` are 0 and `lk_next` is `lk_pc`+1 modulo 2^PC_W (0xFFFF gives 0x0000 at PC_W=16).
- R3: An entry is selected by the low IDX_W bits of the PC. A lookup hits only if that entry is valid and its tag equals the upper PC_W-IDX_W bits of the PC.
- R4: A resolve (`rs_valid`=1) that misses writes the selected entry as valid with the new tag, the reported target and counter value 2. Any entry previously held there is replaced.
- R5: A taken resolve that hits increments the counter, saturating at 3, and stores the reported target as the entry's target.
- R6: A not-taken resolve that hits decrements the counter, saturating at 0, and leaves the target unchanged.
- R7: On a hit, counter values 2 and 3 give `lk_taken`=1 with `lk_next` = the stored target. Values 0 and 1 give `lk_taken`=0 with `lk_next` = `lk_pc`+1, while `lk_hit` stays 1.
- R8: If a lookup and a resolve touch the same entry in one cycle, the lookup returns the contents from before the resolve. The change is visible from the next cycle.
- R9: While `rs_valid` is 0, the values on the other resolve inputs change no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_hit | output | 1 | Valid entry with matching tag |
| lk_taken | output | 1 | Prediction is taken |
| lk_next | output | PC_W | Predicted next fetch PC |
| rs_valid | input | 1 | A branch resolved this cycle |
| rs_pc | input | PC_W | PC of the resolved branch |
| rs_taken | input | 1 | Resolved outcome was taken |
| rs_target | input | PC_W | Taken target of the resolved branch |

## Verification
The bench builds the block with the defaults PC_W=16 and IDX_W=3, so eight entries and a 13-bit tag. Two PCs that differ only above bit 2, such as 0x0012 and 0x001A, therefore share an index. This makes tag mismatch and entry replacement easy to reach with directed addresses. The 16-bit width also puts the PC+1 wrap at 0xFFFF within reach, and long runs of one outcome drive a single counter against both saturation limits.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int PC_W  = 16,
  parameter int IDX_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_next,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;
  localparam logic [1:0] CTR_INIT = 2'd2;

  logic             vld_q [ENTRIES];
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [PC_W-1:0]  tgt_q [ENTRIES];
  logic [1:0]       ctr_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic             rs_hit;
  logic [PC_W-1:0]  lk_seq;

  assign lk_idx = lk_pc[IDX_W-1:0];
  assign lk_tag = lk_pc[PC_W-1:IDX_W];
  assign rs_idx = rs_pc[IDX_W-1:0];
  assign rs_tag = rs_pc[PC_W-1:IDX_W];

  assign lk_seq   = lk_pc + {{(PC_W-1){1'b0}}, 1'b1};
  assign lk_hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_taken = lk_hit && ctr_q[lk_idx][1];
  assign lk_next  = lk_taken ? tgt_q[lk_idx] : lk_seq;

  assign rs_hit = vld_q[rs_idx] && (tag_q[rs_idx] == rs_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
        ctr_q[i] <= '0;
      end
    end else if (rs_valid) begin
      if (!rs_hit) begin
        vld_q[rs_idx] <= 1'b1;
        tag_q[rs_idx] <= rs_tag;
        tgt_q[rs_idx] <= rs_target;
        ctr_q[rs_idx] <= CTR_INIT;
      end else if (rs_taken) begin
        tgt_q[rs_idx] <= rs_target;
        if (ctr_q[rs_idx] != 2'd3) ctr_q[rs_idx] <= ctr_q[rs_idx] + 2'd1;
      end else begin
        if (ctr_q[rs_idx] != 2'd0) ctr_q[rs_idx] <= ctr_q[rs_idx] - 2'd1;
      end
    end
  end

  AST_MISS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_taken && lk_next == lk_seq)); // R2
  AST_ALLOC_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |=> (vld_q[$past(rs_idx)] && ctr_q[$past(rs_idx)] == CTR_INIT
                               && tgt_q[$past(rs_idx)] == $past(rs_target))); // R4
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit && rs_taken && ctr_q[rs_idx] == 2'd3) |=> ctr_q[$past(rs_idx)] == 2'd3); // R5
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit && !rs_taken && ctr_q[rs_idx] == 2'd0) |=> ctr_q[$past(rs_idx)] == 2'd0); // R6
  AST_TAKEN_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_taken) |-> lk_next == tgt_q[lk_idx]); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs_valid && $past(rst_n)) |=> (ctr_q[$past(rs_idx)] == $past(ctr_q[rs_idx])
                     && vld_q[$past(rs_idx)] == $past(vld_q[rs_idx]))); // R9
endmodule

// File: tb/test_btb_predictor.sv
module test_btb_predictor;
  localparam int CLK_P = 10;
  localparam int PC_W  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            lk_hit, lk_taken;
  logic [PC_W-1:0] lk_next;
  logic            rs_valid = 1'b0;
  logic [PC_W-1:0] rs_pc = '0;
  logic            rs_taken = 1'b0;
  logic [PC_W-1:0] rs_target = '0;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(3)) i_btb_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_next(lk_next), .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_target(rs_target));

  task automatic look(input logic [PC_W-1:0] pc, input logic eh, input logic et,
                      input logic [PC_W-1:0] en, input string req);
    lk_pc = pc;
    #1;
    checks++;
    if (lk_hit !== eh || lk_taken !== et || lk_next !== en) begin
      errors++;
      $display("FAIL %s pc=%h: hit/taken/next got %b/%b/%h expected %b/%b/%h",
               req, pc, lk_hit, lk_taken, lk_next, eh, et, en);
    end
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tg);
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = tk; rs_target = tg;
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  task automatic t_reset;
    look(16'h0010, 0, 0, 16'h0011, "R1");
    look(16'h0012, 0, 0, 16'h0013, "R1");
  endtask

  task automatic t_wrap;
    look(16'hFFFF, 0, 0, 16'h0000, "R2");
  endtask

  task automatic t_alloc;
    resolve(16'h0012, 1'b1, 16'h0040);
    look(16'h0012, 1, 1, 16'h0040, "R4/R7 new entry counter 2");
    look(16'h001A, 0, 0, 16'h001B, "R3 tag mismatch");
  endtask

  task automatic t_down;
    resolve(16'h0012, 1'b0, 16'h0040);
    look(16'h0012, 1, 0, 16'h0013, "R6/R7 counter 1");
    resolve(16'h0012, 1'b0, 16'h0040);
    resolve(16'h0012, 1'b0, 16'h0040);
    resolve(16'h0012, 1'b1, 16'h0040);
    look(16'h0012, 1, 0, 16'h0013, "R6 saturate at 0 then up to 1");
    resolve(16'h0012, 1'b1, 16'h0040);
    look(16'h0012, 1, 1, 16'h0040, "R6 counter 2");
  endtask

  task automatic t_up;
    for (int k = 0; k < 3; k++) resolve(16'h0012, 1'b1, 16'h0040);
    resolve(16'h0012, 1'b0, 16'h0040);
    look(16'h0012, 1, 1, 16'h0040, "R5 saturate at 3 then down to 2");
    resolve(16'h0012, 1'b0, 16'h0040);
    look(16'h0012, 1, 0, 16'h0013, "R5 counter 1");
    resolve(16'h0012, 1'b1, 16'h0050);
    resolve(16'h0012, 1'b1, 16'h0055);
    look(16'h0012, 1, 1, 16'h0055, "R5 target refreshed");
  endtask

  task automatic t_replace;
    resolve(16'h001A, 1'b1, 16'h0077);
    look(16'h001A, 1, 1, 16'h0077, "R4 replacement");
    look(16'h0012, 0, 0, 16'h0013, "R3/R4 old branch evicted");
  endtask

  task automatic t_idle;
    @(negedge clk);
    rs_valid = 1'b0; rs_pc = 16'h001A; rs_taken = 1'b0; rs_target = 16'h0099;
    repeat (4) @(negedge clk);
    rs_pc = 16'h0033; rs_taken = 1'b1;
    repeat (2) @(negedge clk);
    look(16'h001A, 1, 1, 16'h0077, "R9 idle resolve inputs");
    look(16'h0033, 0, 0, 16'h0034, "R9 no allocation");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = 16'h0030; rs_taken = 1'b1; rs_target = 16'h0100;
    look(16'h0030, 0, 0, 16'h0031, "R8 old contents same cycle");
    @(posedge clk);
    #1;
    rs_valid = 1'b0;
    look(16'h0030, 1, 1, 16'h0100, "R8 visible next cycle");
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_wrap;
    t_alloc;
    t_down;
    t_up;
    t_replace;
    t_idle;
    t_same_cycle;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule